// File: doc/BRIEF.md
# Parallel-Move Suffix Decoder

This block examines the low byte of a 16-bit DSP instruction and treats it as an optional parallel-move suffix that runs alongside the main operation. For each phase strobe it issues one cycle of registered commands. These cover data-memory reads and writes, which address pointer supplies each access, which register-file entry is the source or destination, and what post-modification the address-register unit should apply to the pointers involved. It does not touch the program counter.

Each instruction is presented twice: once in a prologue phase and once in an epilogue phase. Most suffix classes do their work in the prologue only. The store/load pair class is the exception: its store goes out in the prologue and its load in the epilogue, so the memory traffic can overlap the main arithmetic. Bits 7:4 of the instruction pick the suffix class, and the lower bits select registers and update modes. The main opcode and the memory are outside the block.

Top module: `xop_decode`

## Requirements
- R1: After reset every output is 0. In the cycle after a clock edge where `phase_vld` is low, every output is 0. Any field whose enable is low always reads 0.
- R2: If insn[7:0] is 0x00, all outputs are 0 after the strobe, in both phases.
- R3: Class 0x0 (insn[7:4]), prologue: `upd_a_en`=1, `upd_a_ptr`=insn[1:0], `upd_a_mode`=insn[3:2]. The mode codes are 0 clear, 1 decrement, 2 increment, 3 add index.
- R4: Class 0x1, prologue: `mv_en`=1, `mv_src`=insn[1:0] (accumulator-low number), `mv_dst`=insn[3:2] (input register number). Nothing else is asserted.
- R5: Classes 0x2–0x3, prologue: `wr_en`=1, `wr_ptr`=insn[1:0], `wr_src`={0,insn[4:3]}. Pointer insn[1:0] is updated on port A with mode 2 if insn[2]=0, or mode 3 if insn[2]=1.
- R6: Classes 0x4–0x7, prologue: `rd0_en`=1, `rd0_ptr`=insn[1:0], `rd0_dst`=insn[5:3] (index 0–7 of the eight input registers). Port A updates insn[1:0] with mode 2/3 chosen by insn[2].
- R7: Classes 0xC–0xF, prologue: both reads are issued. Read 0 uses pointer insn[1:0] with `rd0_dst`={0,insn[5],0}. Read 1 always uses pointer 3 with `rd1_dst`={0,insn[4],1}. Port A updates insn[1:0] (mode from insn[2]). Port B updates pointer 3 (mode from insn[3]). This holds even when insn[1:0]=3.
- R8: Classes 0x8–0xB, prologue: `wr_en`=1, `wr_src`={1,0,insn[0]} (mid accumulator). If insn[1]=1 the store uses pointer 0 with mode from insn[2]. If insn[1]=0 it uses pointer 3 with mode from insn[3]. The update is on port A.
- R9: Classes 0x8–0xB, epilogue: `rd0_en`=1, `rd0_dst`={0,insn[5:4]}. If insn[1]=1 the load uses pointer 3 with mode from insn[3]. If insn[1]=0 it uses pointer 0 with mode from insn[2]. The update is on port A.
- R10: In the epilogue, every class other than 0x8–0xB produces all-zero outputs.
- R11: Outputs appear on the clock edge after the one that samples `phase_vld`=1 and last exactly one cycle. The write strobe and read 0 are never asserted together.
- R12: insn[15:8] has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| phase_vld | input | 1 | Phase strobe, one cycle per phase |
| phase_epi | input | 1 | 0 = prologue, 1 = epilogue |
| insn | input | 16 | Instruction word |
| rd0_en | output | 1 | First memory read strobe |
| rd0_ptr | output | 2 | Pointer for first read |
| rd0_dst | output | 3 | Input-register index for first read |
| rd1_en | output | 1 | Second read strobe (pointer 3) |
| rd1_dst | output | 3 | Input-register index for second read |
| wr_en | output | 1 | Memory write strobe |
| wr_ptr | output | 2 | Pointer for the write |
| wr_src | output | 3 | Write source: 0–3 accumulator-low/high set, 4–5 mid accumulator |
| mv_en | output | 1 | Register move strobe |
| mv_src | output | 2 | Accumulator-low source |
| mv_dst | output | 2 | Input register destination |
| upd_a_en | output | 1 | Pointer update request A |
| upd_a_ptr | output | 2 | Pointer for update A |
| upd_a_mode | output | 2 | Mode for update A |
| upd_b_en | output | 1 | Pointer-3 update request B |
| upd_b_mode | output | 2 | Mode for update B |

## Verification
The hardest situations to reach are the pair class in the epilogue and the dual load whose first pointer is itself pointer 3. In the second case both update ports name the same register and the read pointers coincide. Both are only visible when the phase flag and the specific low bits line up. Seeded random instruction words with a random phase flag cover all sixteen classes in both phases. Directed cases pin the four pair combinations, the dual load through pointer 3, a zero suffix with a busy upper byte, and an idle cycle after each strobe.

// File: rtl/xop_decode.sv
module xop_decode (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        phase_vld,
  input  logic        phase_epi,
  input  logic [15:0] insn,
  output logic        rd0_en,
  output logic [1:0]  rd0_ptr,
  output logic [2:0]  rd0_dst,
  output logic        rd1_en,
  output logic [2:0]  rd1_dst,
  output logic        wr_en,
  output logic [1:0]  wr_ptr,
  output logic [2:0]  wr_src,
  output logic        mv_en,
  output logic [1:0]  mv_src,
  output logic [1:0]  mv_dst,
  output logic        upd_a_en,
  output logic [1:0]  upd_a_ptr,
  output logic [1:0]  upd_a_mode,
  output logic        upd_b_en,
  output logic [1:0]  upd_b_mode
);
  localparam logic [1:0] M_INC = 2'd2;
  localparam logic [1:0] M_IDX = 2'd3;
  localparam logic [1:0] P3    = 2'd3;

  logic [7:0] op;
  logic       unused_hi;
  logic       pro, epi;
  logic [1:0] md2, md3, st_ptr, st_mode, ld_ptr, ld_mode;

  assign op        = insn[7:0];
  assign unused_hi = ^insn[15:8];
  assign pro = phase_vld && (op != 8'h00) && !phase_epi;
  assign epi = phase_vld && (op != 8'h00) &&  phase_epi;

  assign md2     = op[2] ? M_IDX : M_INC;
  assign md3     = op[3] ? M_IDX : M_INC;
  assign st_ptr  = op[1] ? 2'd0 : P3;
  assign st_mode = op[1] ? md2  : md3;
  assign ld_ptr  = op[1] ? P3   : 2'd0;
  assign ld_mode = op[1] ? md3  : md2;

  logic       n_rd0_en, n_rd1_en, n_wr_en, n_mv_en, n_ua_en, n_ub_en;
  logic [1:0] n_rd0_ptr, n_wr_ptr, n_mv_src, n_mv_dst, n_ua_ptr, n_ua_mode, n_ub_mode;
  logic [2:0] n_rd0_dst, n_rd1_dst, n_wr_src;

  always_comb begin
    n_rd0_en = 1'b0; n_rd0_ptr = '0; n_rd0_dst = '0;
    n_rd1_en = 1'b0; n_rd1_dst = '0;
    n_wr_en  = 1'b0; n_wr_ptr  = '0; n_wr_src  = '0;
    n_mv_en  = 1'b0; n_mv_src  = '0; n_mv_dst  = '0;
    n_ua_en  = 1'b0; n_ua_ptr  = '0; n_ua_mode = '0;
    n_ub_en  = 1'b0; n_ub_mode = '0;
    if (pro) begin
      casez (op[7:4])
        4'b0000: begin
          n_ua_en = 1'b1; n_ua_ptr = op[1:0]; n_ua_mode = op[3:2];
        end
        4'b0001: begin
          n_mv_en = 1'b1; n_mv_src = op[1:0]; n_mv_dst = op[3:2];
        end
        4'b001?: begin
          n_wr_en = 1'b1; n_wr_ptr = op[1:0]; n_wr_src = {1'b0, op[4:3]};
          n_ua_en = 1'b1; n_ua_ptr = op[1:0]; n_ua_mode = md2;
        end
        4'b01??: begin
          n_rd0_en = 1'b1; n_rd0_ptr = op[1:0]; n_rd0_dst = op[5:3];
          n_ua_en  = 1'b1; n_ua_ptr  = op[1:0]; n_ua_mode = md2;
        end
        4'b10??: begin
          n_wr_en = 1'b1; n_wr_ptr = st_ptr; n_wr_src = {2'b10, op[0]};
          n_ua_en = 1'b1; n_ua_ptr = st_ptr; n_ua_mode = st_mode;
        end
        default: begin
          n_rd0_en = 1'b1; n_rd0_ptr = op[1:0]; n_rd0_dst = {1'b0, op[5], 1'b0};
          n_rd1_en = 1'b1; n_rd1_dst = {1'b0, op[4], 1'b1};
          n_ua_en  = 1'b1; n_ua_ptr  = op[1:0]; n_ua_mode = md2;
          n_ub_en  = 1'b1; n_ub_mode = md3;
        end
      endcase
    end else if (epi && op[7:6] == 2'b10) begin
      n_rd0_en = 1'b1; n_rd0_ptr = ld_ptr; n_rd0_dst = {1'b0, op[5:4]};
      n_ua_en  = 1'b1; n_ua_ptr  = ld_ptr; n_ua_mode = ld_mode;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd0_en <= 1'b0; rd0_ptr <= '0; rd0_dst <= '0;
      rd1_en <= 1'b0; rd1_dst <= '0;
      wr_en  <= 1'b0; wr_ptr  <= '0; wr_src  <= '0;
      mv_en  <= 1'b0; mv_src  <= '0; mv_dst  <= '0;
      upd_a_en <= 1'b0; upd_a_ptr <= '0; upd_a_mode <= '0;
      upd_b_en <= 1'b0; upd_b_mode <= '0;
    end else begin
      rd0_en <= n_rd0_en; rd0_ptr <= n_rd0_ptr; rd0_dst <= n_rd0_dst;
      rd1_en <= n_rd1_en; rd1_dst <= n_rd1_dst;
      wr_en  <= n_wr_en;  wr_ptr  <= n_wr_ptr;  wr_src  <= n_wr_src;
      mv_en  <= n_mv_en;  mv_src  <= n_mv_src;  mv_dst  <= n_mv_dst;
      upd_a_en <= n_ua_en; upd_a_ptr <= n_ua_ptr; upd_a_mode <= n_ua_mode;
      upd_b_en <= n_ub_en; upd_b_mode <= n_ub_mode;
    end
  end
endmodule

// File: rtl/xop_decode_chk.sv
module xop_decode_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        phase_vld,
  input logic        phase_epi,
  input logic [15:0] insn,
  input logic        rd0_en,
  input logic        rd1_en,
  input logic        wr_en,
  input logic        mv_en,
  input logic        upd_a_en,
  input logic        upd_b_en
);
  logic any_act;
  assign any_act = rd0_en | rd1_en | wr_en | mv_en | upd_a_en | upd_b_en;

  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(phase_vld) |-> !any_act);

  p_zero_suffix_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(phase_vld) && $past(insn[7:0]) == 8'h00) |-> !any_act);

  p_epi_pair_only_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(phase_vld) && $past(phase_epi) && $past(insn[7:6]) != 2'b10) |-> !any_act);

  p_rw_exclusive_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && rd0_en));

  p_dual_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd1_en |-> (rd0_en && upd_b_en && upd_a_en));

  p_move_alone_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mv_en |-> !(rd0_en | rd1_en | wr_en | upd_a_en | upd_b_en));
endmodule

bind xop_decode xop_decode_chk u_chk (
  .clk(clk), .rst_n(rst_n), .phase_vld(phase_vld), .phase_epi(phase_epi),
  .insn(insn), .rd0_en(rd0_en), .rd1_en(rd1_en), .wr_en(wr_en),
  .mv_en(mv_en), .upd_a_en(upd_a_en), .upd_b_en(upd_b_en)
);

// File: tb/sim_xop_decode.sv
`timescale 1ns/1ps
module sim_xop_decode;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic phase_vld = 1'b0;
  logic phase_epi = 1'b0;
  logic [15:0] insn = '0;
  logic rd0_en, rd1_en, wr_en, mv_en, upd_a_en, upd_b_en;
  logic [1:0] rd0_ptr, wr_ptr, mv_src, mv_dst, upd_a_ptr, upd_a_mode, upd_b_mode;
  logic [2:0] rd0_dst, rd1_dst, wr_src;

  always #2 clk = ~clk;

  xop_decode u0 (.*);

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  function automatic logic [28:0] outs();
    return {rd0_en, rd0_ptr, rd0_dst, rd1_en, rd1_dst, wr_en, wr_ptr, wr_src,
            mv_en, mv_src, mv_dst, upd_a_en, upd_a_ptr, upd_a_mode, upd_b_en, upd_b_mode};
  endfunction

  function automatic logic [1:0] stepm(input logic b);
    return b ? 2'd3 : 2'd2;
  endfunction

  function automatic logic [28:0] model(input logic [7:0] s, input logic e);
    logic r0e = 0, r1e = 0, we = 0, me = 0, ae = 0, be = 0;
    logic [1:0] r0p = 0, wp = 0, ms = 0, md = 0, ap = 0, am = 0, bm = 0;
    logic [2:0] r0d = 0, r1d = 0, ws = 0;
    int c = s[7:4];
    if (s != 0) begin
      if (e) begin
        if (c >= 8 && c <= 11) begin
          r0e = 1; r0d = {1'b0, s[5:4]}; ae = 1;
          if (s[1]) begin r0p = 3; am = stepm(s[3]); end
          else      begin r0p = 0; am = stepm(s[2]); end
          ap = r0p;
        end
      end else if (c == 0) begin
        ae = 1; ap = s[1:0]; am = s[3:2];
      end else if (c == 1) begin
        me = 1; ms = s[1:0]; md = s[3:2];
      end else if (c <= 3) begin
        we = 1; wp = s[1:0]; ws = {1'b0, s[4:3]}; ae = 1; ap = s[1:0]; am = stepm(s[2]);
      end else if (c <= 7) begin
        r0e = 1; r0p = s[1:0]; r0d = s[5:3]; ae = 1; ap = s[1:0]; am = stepm(s[2]);
      end else if (c <= 11) begin
        we = 1; ws = s[0] ? 3'd5 : 3'd4; ae = 1;
        if (s[1]) begin wp = 0; am = stepm(s[2]); end
        else      begin wp = 3; am = stepm(s[3]); end
        ap = wp;
      end else begin
        r0e = 1; r0p = s[1:0]; r0d = s[5] ? 3'd2 : 3'd0;
        r1e = 1; r1d = s[4] ? 3'd3 : 3'd1;
        ae = 1; ap = s[1:0]; am = stepm(s[2]); be = 1; bm = stepm(s[3]);
      end
    end
    return {r0e, r0p, r0d, r1e, r1d, we, wp, ws, me, ms, md, ae, ap, am, be, bm};
  endfunction

  function automatic string tag(input logic [7:0] s, input logic e);
    int c = s[7:4];
    if (s == 0) return "R2";
    if (e) return (c >= 8 && c <= 11) ? "R9" : "R10";
    if (c == 0) return "R3";
    if (c == 1) return "R4";
    if (c <= 3) return "R5";
    if (c <= 7) return "R6";
    if (c <= 11) return "R8";
    return "R7";
  endfunction

  task automatic check(input logic [28:0] exp, input string req, input logic [15:0] w);
    tests++;
    if (outs() !== exp) begin
      fails++;
      $display("FAIL %s insn=%h got=%h exp=%h", req, w, outs(), exp);
    end
  endtask

  task automatic run(input logic [15:0] w, input logic e);
    @(negedge clk);
    insn = w; phase_epi = e; phase_vld = 1'b1;
    @(negedge clk);
    check(model(w[7:0], e), tag(w[7:0], e), w);
    phase_vld = 1'b0; insn = $urandom;
    @(negedge clk);
    check('0, "R11", w);
  endtask

  initial begin
    int seed;
    seed = $urandom(32'd20240517);
    repeat (3) @(negedge clk);
    check('0, "R1", 16'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check('0, "R1", 16'h0);
    run(16'hAB00, 1'b0);
    run(16'hFF00, 1'b1);
    run(16'h0003, 1'b0);
    run(16'h000E, 1'b0);
    run(16'h001B, 1'b0);
    run(16'h003D, 1'b0);
    run(16'h006E, 1'b0);
    run(16'h0083, 1'b0);
    run(16'h0083, 1'b1);
    run(16'h008C, 1'b0);
    run(16'h008C, 1'b1);
    run(16'h00B6, 1'b0);
    run(16'h00B6, 1'b1);
    run(16'h00F7, 1'b0);
    run(16'h00FB, 1'b1);
    run(16'h0035, 1'b1);
    begin
      logic [28:0] a;
      run(16'h0035, 1'b0);
      @(negedge clk); insn = 16'h0035; phase_epi = 0; phase_vld = 1;
      @(negedge clk); a = outs();
      insn = 16'hC335;
      @(negedge clk);
      check(a, "R12", 16'hC335);
      phase_vld = 0;
      @(negedge clk);
    end
    for (int i = 0; i < 3000; i++) run(16'($urandom), 1'($urandom));
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule